// File: doc/BRIEF.md
# Scan-List A/D Conversion Sequencer

This block sits between a 16-bit host register bus and a behavioural multi-channel A/D converter that samples all its inputs at once. Software chooses channels by writing a bitmask. It then reads a trigger address. That read has a side effect: the block discards any unread results, emits a single sample pulse carrying the mask, and then asks the converter for each selected channel in turn, lowest channel first. Each result is stored in a small FIFO. A busy flag is high while a scan runs and drops once the last selected result is stored.

Results are read back through a window of eight consecutive 16-bit addresses. Every read anywhere in that window takes the next FIFO entry. A 32-bit host access that the bridge splits into two 16-bit cycles therefore returns two consecutive results.

The converter side uses two valid/ready channels. On the request channel, `req_valid` and `req_chan` are held unchanged until the converter raises `req_ready`, so the converter can stall a request for as long as it needs. On the result channel, `res_ready` is high only while the block waits for the result it asked for, and the converter must hold `res_valid` and `res_data` until it sees `res_ready`. Only one request is outstanding at any time. The bus has no back-pressure: each read strobe produces read data one cycle later.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, `conv_busy` is 0, the status read (address 0x30, bit 0) returns 0, the select register reads 0, the FIFO is empty, and `smp_start` and `req_valid` are low.
- R2: The channel-select register at address 0x10 holds bits 7:0 and reads back what was written. Bit n set to 1 puts channel n in the scan list.
- R3: A read at address 0x20 while idle with a non-zero select starts a scan. The start empties the FIFO, gives exactly one one-cycle `smp_start` pulse with `smp_mask` equal to the select value, and sets the busy flag so that a status read in the next cycle returns bit 0 = 1.
- R4: Channels are requested one at a time, in ascending order, only for selected channels. `req_valid` and `req_chan` stay stable until `req_ready` is seen.
- R5: Results are written to the FIFO in request order, one per `res_valid`/`res_ready` handshake. `res_ready` is high only while a request is outstanding.
- R6: The busy flag falls in the cycle the last selected result is stored and stays 0 until the next start.
- R7: A start read while busy is ignored: no new pulse, no flush, and the running scan continues with its original list.
- R8: A start read with an empty select completes at once. It empties the FIFO, produces no sample pulse, and leaves the busy flag at 0.
- R9: A read at any of the addresses 0x00, 0x02, …, 0x0E pops the next FIFO entry. The result is in bits 13:0 as 14-bit two's complement, and bits 15:14 read 0.
- R10: A data read from an empty FIFO returns 0 and leaves the FIFO unchanged, so later results are still returned in the correct order.
- R11: `bus_rvalid` is high exactly one cycle after each `bus_rd`, and carries the read data in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 6 | Byte address of the 16-bit register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| conv_busy | output | 1 | Scan in progress (same as status bit 0) |
| smp_start | output | 1 | One-cycle simultaneous-sample pulse |
| smp_mask | output | 8 | Channels sampled by the latest pulse |
| req_valid | output | 1 | Conversion request valid |
| req_ready | input | 1 | Converter accepts the request |
| req_chan | output | 3 | Channel being requested |
| res_valid | input | 1 | Converter result valid |
| res_ready | output | 1 | Block accepts the result |
| res_data | input | 14 | Converted value, two's complement |

## Verification
The bench builds the block with its default parameters: eight channels, an eight-entry FIFO and 14-bit results. With these values a full select mask fills the FIFO exactly, and that full scan can be drained through all eight mirror addresses in one pass. These values also put the top channel at the last position of the ascending walk. The converter model stalls requests and varies result latency in a pseudo-random way, so the stability and one-outstanding rules are tested under back-pressure.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int BUS_W   = 16;
  // byte offsets on the register bus
  localparam int OFS_SEL   = 'h10;
  localparam int OFS_START = 'h20;
  localparam int OFS_STAT  = 'h30;
  localparam int DATA_WIN  = 'h10;  // data window spans 0x00..0x0F

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SAMPLE = 2'd1,
    SQ_REQ    = 2'd2,
    SQ_WAIT   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/scan_fifo.sv
module scan_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_p, rd_p;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign do_push = push && (cnt != CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_p];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_p <= '0;
      rd_p <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) begin
        mem[wr_p] <= push_data;
        wr_p      <= nxt(wr_p);
      end
      if (do_pop) rd_p <= nxt(rd_p);
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 14
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [NCH-1:0]         sel,
  output logic                   flush,
  output logic                   busy,
  output logic                   smp_start,
  output logic [NCH-1:0]         smp_mask,
  output logic                   req_valid,
  input  logic                   req_ready,
  output logic [$clog2(NCH)-1:0] req_chan,
  input  logic                   res_valid,
  output logic                   res_ready,
  input  logic [DW-1:0]          res_data,
  output logic                   push,
  output logic [DW-1:0]          push_data
);
  localparam int CHW = $clog2(NCH);

  seq_state_e     st;
  logic [NCH-1:0] pending;
  logic [CHW-1:0] low_ch;

  // lowest pending channel wins
  always_comb begin
    low_ch = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pending[i]) low_ch = CHW'(i);
  end

  assign busy      = (st != SQ_IDLE);
  assign flush     = start && (st == SQ_IDLE);
  assign req_valid = (st == SQ_REQ);
  assign req_chan  = low_ch;
  assign res_ready = (st == SQ_WAIT);
  assign push      = res_ready && res_valid;
  assign push_data = res_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      pending   <= '0;
      smp_start <= 1'b0;
      smp_mask  <= '0;
    end else begin
      smp_start <= 1'b0;
      unique case (st)
        SQ_IDLE: if (start && (sel != '0)) begin
          pending   <= sel;
          smp_mask  <= sel;
          smp_start <= 1'b1;
          st        <= SQ_SAMPLE;
        end
        SQ_SAMPLE: st <= SQ_REQ;
        SQ_REQ: if (req_ready) begin
          pending[low_ch] <= 1'b0;
          st              <= SQ_WAIT;
        end
        SQ_WAIT: if (res_valid) st <= (pending == '0) ? SQ_IDLE : SQ_REQ;
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scan_bus_dec.sv
module scan_bus_dec
  import adc_scan_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 14,
  parameter int AW  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             bus_rvalid,
  input  logic [DW-1:0]    fifo_head,
  input  logic             fifo_empty,
  input  logic             busy,
  output logic             fifo_pop,
  output logic             start,
  output logic [NCH-1:0]   sel
);
  logic             hit_data, hit_sel, hit_start, hit_stat;
  logic [BUS_W-1:0] rd_mux;

  assign hit_data  = (bus_addr < AW'(DATA_WIN));
  assign hit_sel   = (bus_addr == AW'(OFS_SEL));
  assign hit_start = (bus_addr == AW'(OFS_START));
  assign hit_stat  = (bus_addr == AW'(OFS_STAT));

  assign fifo_pop = bus_rd && hit_data;
  assign start    = bus_rd && hit_start;

  always_comb begin
    rd_mux = '0;
    if (hit_data && !fifo_empty) rd_mux = BUS_W'(fifo_head);
    else if (hit_sel)            rd_mux = BUS_W'(sel);
    else if (hit_stat)           rd_mux = BUS_W'(busy);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel        <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
      if (bus_wr && hit_sel) sel <= bus_wdata[NCH-1:0];
    end
  end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DEPTH = 8,
  parameter int DW    = 14,
  parameter int AW    = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_rd,
  input  logic                   bus_wr,
  input  logic [AW-1:0]          bus_addr,
  input  logic [BUS_W-1:0]       bus_wdata,
  output logic [BUS_W-1:0]       bus_rdata,
  output logic                   bus_rvalid,
  output logic                   conv_busy,
  output logic                   smp_start,
  output logic [NCH-1:0]         smp_mask,
  output logic                   req_valid,
  input  logic                   req_ready,
  output logic [$clog2(NCH)-1:0] req_chan,
  input  logic                   res_valid,
  output logic                   res_ready,
  input  logic [DW-1:0]          res_data
);
  logic           start, flush, push, pop, empty;
  logic [DW-1:0]  push_data, head;
  logic [NCH-1:0] sel;

  scan_bus_dec #(.NCH(NCH), .DW(DW), .AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .fifo_head(head), .fifo_empty(empty),
    .busy(conv_busy), .fifo_pop(pop), .start(start), .sel(sel)
  );

  scan_seq #(.NCH(NCH), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .sel(sel), .flush(flush),
    .busy(conv_busy), .smp_start(smp_start), .smp_mask(smp_mask),
    .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .push(push), .push_data(push_data)
  );

  scan_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push),
    .push_data(push_data), .pop(pop), .head(head), .empty(empty)
  );
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
  parameter int NCH = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_rd,
  input logic                   bus_rvalid,
  input logic [15:0]            bus_rdata,
  input logic                   conv_busy,
  input logic                   smp_start,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic [$clog2(NCH)-1:0] req_chan,
  input logic                   res_ready
);
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_chan));
  p_req_in_scan_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> conv_busy);
  p_one_outstanding_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_valid, res_ready}));
  p_res_in_scan_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready |-> conv_busy);
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_start |=> !smp_start);
  p_pulse_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_start |-> conv_busy);
  p_no_pulse_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy && !smp_start |=> !smp_start);
  p_rvalid_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  p_rvalid_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> bus_rdata[15:14] == 2'b00);
endmodule

bind adc_scan_ctrl adc_scan_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_rvalid(bus_rvalid),
  .bus_rdata(bus_rdata), .conv_busy(conv_busy), .smp_start(smp_start),
  .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
  .res_ready(res_ready)
);

// File: tb/adc_scan_ctrl_tb_top.sv
module adc_scan_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid, conv_busy, smp_start, req_valid, res_ready;
  logic [7:0]  smp_mask;
  logic [2:0]  req_chan;
  logic        req_ready = 1'b0, res_valid = 1'b0;
  logic [13:0] res_data = '0;

  always #10 clk = ~clk;  // 50 MHz

  adc_scan_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .conv_busy(conv_busy), .smp_start(smp_start),
    .smp_mask(smp_mask), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data)
  );

  int errors = 0, checks = 0;
  int pulses = 0, exp_pulses = 0, scan_seen = 0, drv_scan = 0;
  logic [7:0]  last_mask = '0, sel_m = '0;
  logic [15:0] last_rd = '0;
  bit          busy_m = 0, finished = 0;
  int    exp_q[$];
  string tag_q[$];
  bit    chk_q[$];
  int    fm[$];
  int    ch_q[$];

  function automatic int cdata(int sc, int ch);
    return (sc * 37 + ch * 613 + 8000) & 'h3FFF;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  initial forever begin
    @(negedge clk);
    if (rst_n && smp_start) begin
      pulses++; last_mask = smp_mask; scan_seen++;
    end
    if (bus_rvalid) begin
      last_rd = bus_rdata;
      if (exp_q.size() == 0) check(0, "R11 unexpected rvalid", 1, 0);
      else begin
        int e; string t; bit c;
        e = exp_q.pop_front(); t = tag_q.pop_front(); c = chk_q.pop_front();
        if (c) check(bus_rdata == 16'(e), t, bus_rdata, e);
      end
    end
  end

  // behavioural converter with stalls and variable latency
  initial begin
    logic [7:0] lf = 8'h5B;
    int ch, lat;
    forever begin
      @(negedge clk);
      if (!rst_n || !req_valid) begin req_ready = 0; continue; end
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      if (lf[0]) begin req_ready = 0; continue; end
      req_ready = 1; ch = int'(req_chan);
      if (ch_q.size() == 0) check(0, "R4 unexpected request", ch, -1);
      else begin
        int ec; ec = ch_q.pop_front();
        check(ch == ec, "R4 request order", ch, ec);
      end
      @(negedge clk); req_ready = 0;
      lat = int'(lf[2:1]);
      repeat (lat) @(negedge clk);
      res_valid = 1; res_data = 14'(cdata(scan_seen, ch));
      while (!res_ready) @(negedge clk);
      @(negedge clk); res_valid = 0;
    end
  end

  task automatic rd(logic [5:0] a, int exp, bit c, string tag);
    bus_rd = 1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag); chk_q.push_back(c);
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
    if (a == 6'h10) sel_m = d[7:0];
  endtask

  task automatic rd_data(logic [5:0] a, string tag);
    int e;
    e = (fm.size() == 0) ? 0 : fm.pop_front();
    rd(a, e, 1, tag);
  endtask

  task automatic start_scan();
    if (!busy_m) begin
      fm.delete();
      if (sel_m != 0) begin
        drv_scan++; exp_pulses++; busy_m = 1;
        for (int i = 0; i < 8; i++)
          if (sel_m[i]) begin fm.push_back(cdata(drv_scan, i)); ch_q.push_back(i); end
      end
    end
    rd(6'h20, 0, 0, "");
  endtask

  task automatic wait_idle();
    int n = 0;
    do begin
      rd(6'h30, 0, 0, "");
      @(negedge clk); #1;
      n++;
    end while (last_rd[0] && n < 300);
    check(n < 300, "R6 scan completes", n, 300);
    busy_m = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(conv_busy == 0, "R1 busy after reset", conv_busy, 0);
    check(req_valid == 0 && smp_start == 0, "R1 outputs idle", {req_valid, smp_start}, 0);
    rd(6'h30, 0, 1, "R1 status after reset");
    rd(6'h10, 0, 1, "R1 select after reset");
    rd_data(6'h00, "R10 empty read after reset");
    @(negedge clk);

    // R2 select write/readback
    wr(6'h10, 16'h00A5);
    rd(6'h10, 'hA5, 1, "R2 select readback");
    // R3 start, busy next cycle
    start_scan();
    rd(6'h30, 1, 1, "R3 busy after start");
    wait_idle();
    check(pulses == exp_pulses, "R3 one sample pulse", pulses, exp_pulses);
    check(last_mask == 8'hA5, "R3 sample mask", last_mask, 'hA5);
    // R9 paired mirror reads
    rd_data(6'h00, "R9 data 0x00"); rd_data(6'h02, "R9 data 0x02");
    rd_data(6'h04, "R9 data 0x04"); rd_data(6'h06, "R9 data 0x06");
    rd_data(6'h08, "R10 empty after drain");
    rd_data(6'h0E, "R10 empty again");

    // R7 start while busy ignored
    wr(6'h10, 16'h0081);
    start_scan();
    wr(6'h10, 16'h007E);
    start_scan();          // ignored by design and by model
    wait_idle();
    check(pulses == exp_pulses, "R7 no extra pulse", pulses, exp_pulses);
    check(last_mask == 8'h81, "R7 mask unchanged", last_mask, 'h81);
    rd_data(6'h0A, "R7 first result"); rd_data(6'h0C, "R7 second result");
    rd_data(6'h00, "R7 no further entries");

    // R3 flush of unread entries
    wr(6'h10, 16'h00FF);
    start_scan(); wait_idle();
    rd_data(6'h00, "R5 partial read 0"); rd_data(6'h02, "R5 partial read 1");
    rd_data(6'h04, "R5 partial read 2");
    wr(6'h10, 16'h0012);
    start_scan(); wait_idle();
    rd_data(6'h00, "R3 flushed, ch1"); rd_data(6'h06, "R3 flushed, ch4");
    rd_data(6'h08, "R3 flushed, empty");

    // R8 empty select completes at once and flushes
    wr(6'h10, 16'h0018);
    start_scan(); wait_idle();
    wr(6'h10, 16'h0000);
    start_scan();
    check(conv_busy == 0, "R8 busy stays low", conv_busy, 0);
    rd(6'h30, 0, 1, "R8 status idle");
    rd_data(6'h00, "R8 FIFO emptied");
    check(pulses == exp_pulses, "R8 no pulse", pulses, exp_pulses);

    // R9 full scan through all mirrors
    wr(6'h10, 16'h00FF);
    start_scan(); wait_idle();
    for (int i = 0; i < 8; i++) rd_data(6'(2 * i), "R9 full-scan mirror read");
    rd_data(6'h02, "R10 empty after full drain");

    // R6 busy stays low while idle
    begin
      int hi = 0;
      repeat (20) begin @(negedge clk); if (conv_busy) hi++; end
      check(hi == 0, "R6 busy stays low", hi, 0);
    end
    rd(6'h30, 0, 1, "R6 status still idle");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R11 all reads answered", exp_q.size(), 0);
    check(ch_q.size() == 0, "R4 all channels requested", ch_q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule